// File: doc/BRIEF.md
# Transactional Coherence Conflict Responder

This block sits beside a processor's private cache and answers coherence requests that the directory forwards to it while the processor may be running a transaction. Each forwarded request is either a shared read or an exclusive (ownership) request. It arrives together with the result of the cache tag lookup for every way: a hit vector plus the transactional read and write marks of each way. The block compares the request against those marks and against two pieces of local state. The first is a transaction-active flag. The second is a single overflow flag, which records that a block written inside the current transaction has left the cache.

The reply is one of four codes. Refuse tells the requester to retry later because of a conflict. Data is returned for a shared read that does not conflict. Ack is returned for an exclusive request that does not conflict. Clean means the block is not held here and nothing may be hidden in memory. A missing block is treated conservatively: while the overflow flag is set, a miss is refused even though the evicted block may have been a different one. This keeps the design free of any per-block record outside the cache. Ending the transaction by commit or by abort clears both flags.

Top module: `tx_conflict_responder`

## Requirements
- R1: With the transaction active, a shared-read request (req_excl=0) that hits a way whose write mark is set returns Refuse (code 3).
- R2: With the transaction active, an exclusive request (req_excl=1) that hits a way whose read mark or write mark is set returns Refuse (code 3).
- R3: A hit that does not conflict returns Data (code 0) for a shared read and Ack (code 1) for an exclusive request.
- R4: With the transaction active and the overflow flag set, a request that hits no way returns Refuse (code 3).
- R5: A request that hits no way while the overflow flag is clear returns Clean (code 2).
- R6: An eviction with evict_wr=1 while the transaction is active sets the overflow flag on the next cycle. An eviction with evict_wr=0, or one that occurs while no transaction is active, leaves the flag clear.
- R7: tm_end (commit or abort) clears both the transaction flag and the overflow flag on the next cycle. It takes priority over a tm_begin or an eviction in the same cycle.
- R8: While no transaction is active the read and write marks are ignored and Refuse is never returned.
- R9: The response appears with rsp_valid exactly one cycle after req_valid and carries the request's req_id. It is decided from the flags as they stood in the request cycle, so an eviction or a tm_end in that same cycle does not affect it.
- R10: Reset clears rsp_valid, the transaction flag and the overflow flag. tm_begin sets the transaction flag on the next cycle.
- R11: Marks of ways whose hit bit is clear have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Forwarded request present this cycle |
| req_excl | input | 1 | 1 = exclusive request, 0 = shared read |
| req_id | input | ID_W | Requester identifier, echoed in the response |
| lk_hit | input | WAYS | Tag lookup hit per way (at most one set) |
| lk_rd | input | WAYS | Transactional read mark per way |
| lk_wr | input | WAYS | Transactional write mark per way |
| evict_valid | input | 1 | A block is being written back this cycle |
| evict_wr | input | 1 | The evicted block carries a transactional write mark |
| tm_begin | input | 1 | Transaction starts |
| tm_end | input | 1 | Transaction commits or aborts |
| rsp_valid | output | 1 | Response valid |
| rsp_code | output | 2 | 0 Data, 1 Ack, 2 Clean, 3 Refuse |
| rsp_id | output | ID_W | Identifier of the answered request |
| tm_active | output | 1 | Transaction flag |
| ovf_flag | output | 1 | Overflow flag |

## Verification
The assertions check on every cycle the timing and tag echo of responses, the absence of Refuse outside a transaction, and the refusal of conflicting hits and of misses under overflow. They also check how the flags react to eviction and to transaction end, and that overflow never stands without an active transaction. Only the bench scenarios show the full response table: every way position, every mark pair on the hit way, and inverted marks on the ways that miss, in each flag state. The same holds for ordering corners, where a request shares its cycle with an eviction or a transaction end.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    RSP_DATA   = 2'd0,
    RSP_ACK    = 2'd1,
    RSP_CLEAN  = 2'd2,
    RSP_REFUSE = 2'd3
  } rsp_code_t;
endpackage

// File: rtl/tmr_state.sv
module tmr_state (
  input  logic clk,
  input  logic rst,
  input  logic tm_begin,
  input  logic tm_end,
  input  logic evict_valid,
  input  logic evict_wr,
  output logic tm_on,
  output logic ovf_on
);
  logic spill;
  assign spill = evict_valid & evict_wr & tm_on;

  always_ff @(posedge clk) begin
    if (rst) begin
      tm_on  <= 1'b0;
      ovf_on <= 1'b0;
    end else if (tm_end) begin
      tm_on  <= 1'b0;
      ovf_on <= 1'b0;
    end else begin
      if (tm_begin) tm_on <= 1'b1;
      if (spill)    ovf_on <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_classify.sv
module tmr_classify #(
  parameter int WAYS = 4
) (
  input  logic              excl,
  input  logic [WAYS-1:0]   hit,
  input  logic [WAYS-1:0]   rd,
  input  logic [WAYS-1:0]   wr,
  input  logic              tm_on,
  input  logic              ovf_on,
  output tmr_pkg::rsp_code_t code
);
  logic [WAYS-1:0] way_clash;

  for (genvar i = 0; i < WAYS; i++) begin : g_way
    assign way_clash[i] = hit[i] & (excl ? (rd[i] | wr[i]) : wr[i]);
  end

  logic any_hit, clash;
  assign any_hit = |hit;
  assign clash   = tm_on & (|way_clash);

  always_comb begin
    if (any_hit) begin
      if (clash)     code = tmr_pkg::RSP_REFUSE;
      else if (excl) code = tmr_pkg::RSP_ACK;
      else           code = tmr_pkg::RSP_DATA;
    end else if (tm_on && ovf_on) begin
      code = tmr_pkg::RSP_REFUSE;
    end else begin
      code = tmr_pkg::RSP_CLEAN;
    end
  end
endmodule

// File: rtl/tmr_rsp_stage.sv
module tmr_rsp_stage #(
  parameter int ID_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  tmr_pkg::rsp_code_t in_code,
  input  logic [ID_W-1:0]   in_id,
  output logic              out_valid,
  output logic [1:0]        out_code,
  output logic [ID_W-1:0]   out_id
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= 2'd0;
      out_id    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_code <= in_code;
        out_id   <= in_id;
      end
    end
  end
endmodule

// File: rtl/tx_conflict_responder.sv
module tx_conflict_responder #(
  parameter int WAYS = 4,
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_excl,
  input  logic [ID_W-1:0] req_id,
  input  logic [WAYS-1:0] lk_hit,
  input  logic [WAYS-1:0] lk_rd,
  input  logic [WAYS-1:0] lk_wr,
  input  logic            evict_valid,
  input  logic            evict_wr,
  input  logic            tm_begin,
  input  logic            tm_end,
  output logic            rsp_valid,
  output logic [1:0]      rsp_code,
  output logic [ID_W-1:0] rsp_id,
  output logic            tm_active,
  output logic            ovf_flag
);
  tmr_pkg::rsp_code_t next_code;

  tmr_state u_state (
    .clk(clk), .rst(rst), .tm_begin(tm_begin), .tm_end(tm_end),
    .evict_valid(evict_valid), .evict_wr(evict_wr),
    .tm_on(tm_active), .ovf_on(ovf_flag)
  );

  tmr_classify #(.WAYS(WAYS)) u_cls (
    .excl(req_excl), .hit(lk_hit), .rd(lk_rd), .wr(lk_wr),
    .tm_on(tm_active), .ovf_on(ovf_flag), .code(next_code)
  );

  tmr_rsp_stage #(.ID_W(ID_W)) u_rsp (
    .clk(clk), .rst(rst), .in_valid(req_valid), .in_code(next_code),
    .in_id(req_id), .out_valid(rsp_valid), .out_code(rsp_code),
    .out_id(rsp_id)
  );
endmodule

// File: rtl/tx_conflict_responder_chk.sv
module tx_conflict_responder_chk #(
  parameter int WAYS = 4,
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_excl,
  input logic [ID_W-1:0] req_id,
  input logic [WAYS-1:0] lk_hit,
  input logic [WAYS-1:0] lk_rd,
  input logic [WAYS-1:0] lk_wr,
  input logic            evict_valid,
  input logic            evict_wr,
  input logic            tm_begin,
  input logic            tm_end,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic [ID_W-1:0] rsp_id,
  input logic            tm_active,
  input logic            ovf_flag
);
  // R1
  gets_wr_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && tm_active && !req_excl && |(lk_hit & lk_wr) |=> rsp_code == 2'd3);
  // R2
  getx_mark_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && tm_active && req_excl && |(lk_hit & (lk_rd | lk_wr)) |=> rsp_code == 2'd3);
  // R4
  miss_ovf_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && tm_active && ovf_flag && lk_hit == '0 |=> rsp_code == 2'd3);
  // R5
  miss_clean_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !ovf_flag && lk_hit == '0 |=> rsp_code == 2'd2);
  // R6
  spill_sets_chk: assert property (@(posedge clk) disable iff (rst)
    evict_valid && evict_wr && tm_active && !tm_end |=> ovf_flag);
  // R6
  ovf_needs_tm_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> tm_active);
  // R7
  end_clears_chk: assert property (@(posedge clk) disable iff (rst)
    tm_end |=> !tm_active && !ovf_flag);
  // R8
  no_refuse_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !tm_active |=> rsp_code != 2'd3);
  // R9
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid && rsp_id == $past(req_id));
  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R10
  begin_sets_chk: assert property (@(posedge clk) disable iff (rst)
    tm_begin && !tm_end |=> tm_active);
endmodule

bind tx_conflict_responder tx_conflict_responder_chk #(.WAYS(WAYS), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_excl(req_excl), .req_id(req_id),
  .lk_hit(lk_hit), .lk_rd(lk_rd), .lk_wr(lk_wr), .evict_valid(evict_valid),
  .evict_wr(evict_wr), .tm_begin(tm_begin), .tm_end(tm_end), .rsp_valid(rsp_valid),
  .rsp_code(rsp_code), .rsp_id(rsp_id), .tm_active(tm_active), .ovf_flag(ovf_flag)
);

// File: tb/tx_conflict_responder_tb.sv
module tx_conflict_responder_tb;
  localparam int WAYS = 4;
  localparam int ID_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_excl = 0;
  logic [ID_W-1:0] req_id = '0;
  logic [WAYS-1:0] lk_hit = '0, lk_rd = '0, lk_wr = '0;
  logic evict_valid = 0, evict_wr = 0, tm_begin = 0, tm_end = 0;
  logic rsp_valid;
  logic [1:0] rsp_code;
  logic [ID_W-1:0] rsp_id;
  logic tm_active, ovf_flag;

  int n_chk = 0, n_bad = 0;
  logic [ID_W-1:0] id_ctr = '0;

  always #10 clk = ~clk;

  tx_conflict_responder #(.WAYS(WAYS), .ID_W(ID_W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_excl(req_excl), .req_id(req_id),
    .lk_hit(lk_hit), .lk_rd(lk_rd), .lk_wr(lk_wr), .evict_valid(evict_valid),
    .evict_wr(evict_wr), .tm_begin(tm_begin), .tm_end(tm_end), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .rsp_id(rsp_id), .tm_active(tm_active), .ovf_flag(ovf_flag)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int model(input bit tm, input bit ovf, input bit excl,
                               input int way, input bit r, input bit w);
    if (way >= 0) begin
      if (tm && (excl ? (r || w) : w)) return 3;
      return excl ? 1 : 0;
    end
    return (tm && ovf) ? 3 : 2;
  endfunction

  // way < 0 means miss; non-hit ways get marks inverted by pattern
  task automatic issue(input bit excl, input int way, input bit r, input bit w,
                       input bit other, input int exp, input string req);
    req_valid = 1; req_excl = excl; req_id = id_ctr;
    lk_hit = '0;
    lk_rd = other ? '1 : '0;
    lk_wr = other ? '1 : '0;
    if (way >= 0) begin
      lk_hit[way] = 1'b1; lk_rd[way] = r; lk_wr[way] = w;
    end
    @(negedge clk);
    req_valid = 0; lk_hit = '0; lk_rd = '0; lk_wr = '0;
    check({req, " code"}, int'(rsp_code), exp);
    check("R9 valid", int'(rsp_valid), 1);
    check("R9 id", int'(rsp_id), int'(id_ctr));
    id_ctr++;
  endtask

  task automatic pulse(input bit b, input bit e, input bit ev, input bit evw);
    tm_begin = b; tm_end = e; evict_valid = ev; evict_wr = evw;
    @(negedge clk);
    tm_begin = 0; tm_end = 0; evict_valid = 0; evict_wr = 0;
  endtask

  task automatic set_state(input bit tm, input bit ovf);
    pulse(0, 1, 0, 0);
    if (tm) pulse(1, 0, 0, 0);
    if (ovf) pulse(0, 0, 1, 1);
    check("R10/R6 state tm", int'(tm_active), int'(tm));
    check("R6 state ovf", int'(ovf_flag), int'(ovf));
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check("R10 rsp_valid", int'(rsp_valid), 0);
    check("R10 tm", int'(tm_active), 0);
    check("R10 ovf", int'(ovf_flag), 0);
    @(negedge clk);
    check("R9 idle no rsp", int'(rsp_valid), 0);

    // Sweep: states (tm,ovf) in {00,10,11}
    for (int st = 0; st < 3; st++) begin
      bit tm, ovf;
      tm = (st != 0); ovf = (st == 2);
      set_state(tm, ovf);
      for (int ex = 0; ex < 2; ex++)
        for (int way = -1; way < WAYS; way++)
          for (int rw = 0; rw < 4; rw++)
            for (int oth = 0; oth < 2; oth++) begin
              int e;
              string tag;
              e = model(tm, ovf, ex[0], way, rw[0], rw[1]);
              if (way < 0) tag = ovf ? "R4" : "R5";
              else if (!tm) tag = "R8";
              else if (e == 3) tag = ex[0] ? "R2" : "R1";
              else tag = oth[0] ? "R11" : "R3";
              issue(ex[0], way, rw[0], rw[1], oth[0], e, tag);
            end
    end

    // R6 eviction without write mark leaves overflow clear
    set_state(1, 0);
    pulse(0, 0, 1, 0);
    check("R6 clean evict", int'(ovf_flag), 0);
    // R6 eviction outside transaction leaves overflow clear
    set_state(0, 0);
    pulse(0, 0, 1, 1);
    check("R6 idle evict", int'(ovf_flag), 0);
    // R7 end beats eviction and begin
    set_state(1, 0);
    pulse(1, 1, 1, 1);
    check("R7 end wins tm", int'(tm_active), 0);
    check("R7 end wins ovf", int'(ovf_flag), 0);
    // R9 same-cycle eviction does not affect response
    set_state(1, 0);
    evict_valid = 1; evict_wr = 1;
    issue(0, -1, 0, 0, 0, 2, "R9 pre-evict");
    evict_valid = 0; evict_wr = 0;
    check("R6 ovf after", int'(ovf_flag), 1);
    issue(0, -1, 0, 0, 0, 3, "R4 after evict");
    // R9 same-cycle end does not affect response
    tm_end = 1;
    issue(1, 2, 1, 0, 0, 3, "R9 pre-end");
    tm_end = 0;
    check("R7 tm cleared", int'(tm_active), 0);
    issue(1, 2, 1, 0, 0, 1, "R8 after end");
    issue(1, -1, 0, 0, 0, 2, "R5 after end");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule